// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block stands in for the management-side register set of a simple Ethernet transceiver. It holds 32 words of 16 bits behind a synchronous write port and a combinational read port. Both ports take a request word whose low five bits select the register. A separate serial management front end, outside this block, turns bus frames into these accesses.

Most registers are plain storage that comes out of reset with fixed identity and capability values. Three register numbers are computed on every read:
- The basic status word depends on the link-up input.
- The link-partner word echoes the local advertisement, so negotiation always appears to have succeeded.
- A vendor diagnostic word reports the speed and duplex that would be resolved from the advertised modes.

A `duplex_resolved` output carries the resolved duplex bit, so a MAC can compare it with its own duplex setting. The `DIAG_COMPUTED` parameter can turn the diagnostic register into plain storage.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, register 0 reads 16'h3100, register 2 reads 16'h0300, register 3 reads 16'hE400, register 4 (advertisement) reads 16'h01E1, and every other plain register reads 0.
- R2: Register 1 reads 16'h782C while `link_up` is 1. That value has bits 14, 13, 12 and 11 set (abilities), bit 5 set (negotiation complete), bit 3 set (negotiation able) and bit 2 set (link). It reads 0 while `link_up` is 0.
- R3: Register 5 reads bit 14 set, bit 0 set, and register 4 bits 8:5 in bits 8:5, with all other bits 0, whatever the link state.
- R4: Register 18 reads 0 while `link_up` is 0.
- R5: While `link_up` is 1, register 18 has bit 10 set exactly when register 4 bit 7 or bit 8 is set, and bit 11 set exactly when register 4 bit 8 or bit 6 is set. All other bits are 0.
- R6: Every register number other than 1, 5 and 18 reads back its stored value.
- R7: Writes to registers 1, 5 and 18 are accepted, but their read values keep following R2, R3 and R5.
- R8: Only bits 4:0 of `rd_req` and `wr_req` select the register; upper request bits have no effect.
- R9: `duplex_resolved` always equals the value of register 18 bit 11 given by R4 and R5.
- R10: A write with `wr_en` high takes effect at the rising clock edge. A read in the same cycle returns the old value, and the new value appears once that edge has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link state seen by the computed registers |
| wr_en | input | 1 | Write strobe |
| wr_req | input | REQ_W | Write request; low 5 bits are the register number |
| wr_data | input | DATA_W | Write data |
| rd_req | input | REQ_W | Read request; low 5 bits are the register number |
| rd_data | output | DATA_W | Combinational read data |
| duplex_resolved | output | 1 | Resolved duplex bit from the diagnostic view |

## Verification
The bench builds the block with its defaults: REQ_W of 8, DATA_W of 16, a 5-bit register index and a computed diagnostic register. The 8-bit request leaves three upper bits that random traffic drives freely, which exercises aliasing of every register number. The 16-bit data width makes the exact status and diagnostic words comparable without masking. Random writes to the advertisement register, combined with a link input that toggles, reach every speed and duplex combination of the computed views.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

   localparam int unsigned IDX_CTRL    = 0;
   localparam int unsigned IDX_STATUS  = 1;
   localparam int unsigned IDX_ID_HI   = 2;
   localparam int unsigned IDX_ID_LO   = 3;
   localparam int unsigned IDX_ADV     = 4;
   localparam int unsigned IDX_PARTNER = 5;
   localparam int unsigned IDX_DIAG    = 18;

   // advertisement bit positions
   localparam int unsigned ADV_10F  = 6;
   localparam int unsigned ADV_100H = 7;
   localparam int unsigned ADV_100F = 8;

   // diagnostic bit positions
   localparam int unsigned DIAG_SPD = 10;
   localparam int unsigned DIAG_DUP = 11;

   localparam logic [15:0] STATUS_UP_WORD =
      (16'h1 << 14) | (16'h1 << 13) | (16'h1 << 12) | (16'h1 << 11) |
      (16'h1 << 5)  | (16'h1 << 3)  | (16'h1 << 2);

   localparam logic [15:0] PARTNER_FIXED = (16'h1 << 14) | 16'h1;
   localparam logic [15:0] PARTNER_MASK  = 16'h01E0;

   function automatic logic [15:0] reset_word(int unsigned idx);
      case (idx)
         IDX_CTRL:  return 16'h3100;
         IDX_ID_HI: return 16'h0300;
         IDX_ID_LO: return 16'hE400;
         IDX_ADV:   return 16'h01E1;
         default:   return 16'h0000;
      endcase
   endfunction

endpackage

// File: rtl/phy_reg_store.sv
module phy_reg_store
   import phy_mgmt_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned REG_AW = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [REG_AW-1:0]          wr_idx,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [(1<<REG_AW)*DATA_W-1:0] store_flat
);
   localparam int unsigned NREGS = 1 << REG_AW;

   for (genvar gi = 0; gi < NREGS; gi++) begin : g_word
      localparam logic [DATA_W-1:0] INIT = DATA_W'(reset_word(gi));
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= INIT;
         else if (wr_en && (wr_idx == REG_AW'(gi)))
            q <= wr_data;
      end
      assign store_flat[gi*DATA_W +: DATA_W] = q;
   end

endmodule

// File: rtl/phy_reg_view.sv
module phy_reg_view
   import phy_mgmt_pkg::*;
#(
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned REG_AW        = 5,
   parameter bit          DIAG_COMPUTED = 1'b1
) (
   input  logic [(1<<REG_AW)*DATA_W-1:0] store_flat,
   input  logic [REG_AW-1:0]             rd_idx,
   input  logic                          link_up,
   output logic [DATA_W-1:0]             rd_data,
   output logic                          duplex_resolved
);
   logic [DATA_W-1:0] stored_word;
   logic [DATA_W-1:0] adv_word;
   logic [DATA_W-1:0] status_word;
   logic [DATA_W-1:0] partner_word;
   logic [DATA_W-1:0] diag_word;
   logic              spd100;
   logic              dup_full;

   assign stored_word = store_flat[rd_idx*DATA_W +: DATA_W];
   assign adv_word    = store_flat[IDX_ADV*DATA_W +: DATA_W];

   assign status_word  = link_up ? DATA_W'(STATUS_UP_WORD) : '0;
   assign partner_word = DATA_W'(PARTNER_FIXED) | (adv_word & DATA_W'(PARTNER_MASK));

   assign spd100   = adv_word[ADV_100H] | adv_word[ADV_100F];
   assign dup_full = adv_word[ADV_100F] | adv_word[ADV_10F];

   always_comb begin
      diag_word = '0;
      if (link_up) begin
         diag_word[DIAG_SPD] = spd100;
         diag_word[DIAG_DUP] = dup_full;
      end
   end

   assign duplex_resolved = link_up & dup_full;

   if (DIAG_COMPUTED) begin : g_diag_calc
      always_comb begin
         if (rd_idx == REG_AW'(IDX_STATUS))
            rd_data = status_word;
         else if (rd_idx == REG_AW'(IDX_PARTNER))
            rd_data = partner_word;
         else if (rd_idx == REG_AW'(IDX_DIAG))
            rd_data = diag_word;
         else
            rd_data = stored_word;
      end
   end else begin : g_diag_plain
      always_comb begin
         if (rd_idx == REG_AW'(IDX_STATUS))
            rd_data = status_word;
         else if (rd_idx == REG_AW'(IDX_PARTNER))
            rd_data = partner_word;
         else
            rd_data = stored_word;
      end
   end

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
   import phy_mgmt_pkg::*;
#(
   parameter int unsigned REQ_W         = 8,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned REG_AW        = 5,
   parameter bit          DIAG_COMPUTED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_up,
   input  logic              wr_en,
   input  logic [REQ_W-1:0]  wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [REQ_W-1:0]  rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic              duplex_resolved
);
   localparam int unsigned NREGS = 1 << REG_AW;

   if (REG_AW != 5) begin : g_bad_aw
      $error("phy_mgmt_regs: REG_AW must be 5");
   end
   if (DATA_W < 16) begin : g_bad_dw
      $error("phy_mgmt_regs: DATA_W must be at least 16");
   end
   if (REQ_W < REG_AW) begin : g_bad_rw
      $error("phy_mgmt_regs: REQ_W must cover the register index");
   end

   logic [REG_AW-1:0]       wr_idx;
   logic [REG_AW-1:0]       rd_idx;
   logic [NREGS*DATA_W-1:0] store_flat;

   assign wr_idx = wr_req[REG_AW-1:0];
   assign rd_idx = rd_req[REG_AW-1:0];

   if (REQ_W > REG_AW) begin : g_req_hi
      logic unused_req_hi;
      assign unused_req_hi = ^{wr_req[REQ_W-1:REG_AW], rd_req[REQ_W-1:REG_AW]};
   end

   phy_reg_store #(
      .DATA_W (DATA_W),
      .REG_AW (REG_AW)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .store_flat (store_flat)
   );

   phy_reg_view #(
      .DATA_W        (DATA_W),
      .REG_AW        (REG_AW),
      .DIAG_COMPUTED (DIAG_COMPUTED)
   ) u_view (
      .store_flat      (store_flat),
      .rd_idx          (rd_idx),
      .link_up         (link_up),
      .rd_data         (rd_data),
      .duplex_resolved (duplex_resolved)
   );

endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk #(
   parameter int unsigned REQ_W  = 8,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              link_up,
   input logic              wr_en,
   input logic [REQ_W-1:0]  wr_req,
   input logic [DATA_W-1:0] wr_data,
   input logic [REQ_W-1:0]  rd_req,
   input logic [DATA_W-1:0] rd_data,
   input logic              duplex_resolved
);
   logic [4:0] rd_n;
   logic [4:0] wr_n;
   logic       rd_plain;
   assign rd_n     = rd_req[4:0];
   assign wr_n     = wr_req[4:0];
   assign rd_plain = (rd_n != 5'd1) && (rd_n != 5'd5) && (rd_n != 5'd18);

   // R1: first cycle out of reset shows the control reset word
   a_r1_ctrl_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rst_n) && rd_n == 5'd0) |-> rd_data == DATA_W'(16'h3100));

   // R2: status is zero with the link down
   a_r2_status_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up && rd_n == 5'd1) |-> rd_data == '0);

   // R3: partner word always carries its fixed bits
   a_r3_partner_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n == 5'd5) |-> (rd_data[14] && rd_data[0]));

   // R4: diagnostic word is zero with the link down
   a_r4_diag_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up && rd_n == 5'd18) |-> rd_data == '0);

   // R9: resolved duplex matches the diagnostic bit read out
   a_r9_duplex_match: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n == 5'd18) |-> rd_data[11] == duplex_resolved);

   // R9: no resolved duplex without link
   a_r9_duplex_linkdown: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up |-> !duplex_resolved);

   // R10: a write to a plain register is readable on the next cycle
   a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en) && rd_plain && rd_n == $past(wr_n))
      |-> rd_data == $past(wr_data));

endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(
   .REQ_W  (REQ_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .link_up         (link_up),
   .wr_en           (wr_en),
   .wr_req          (wr_req),
   .wr_data         (wr_data),
   .rd_req          (rd_req),
   .rd_data         (rd_data),
   .duplex_resolved (duplex_resolved)
);

// File: tb/phy_mgmt_regs_tb.sv
module phy_mgmt_regs_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        link_up = 1'b1;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_req = '0;
   logic [15:0] wr_data = '0;
   logic [7:0]  rd_req = '0;
   logic [15:0] rd_data;
   logic        duplex_resolved;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [15:0] mdl [32];

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_mgmt_regs dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .link_up         (link_up),
      .wr_en           (wr_en),
      .wr_req          (wr_req),
      .wr_data         (wr_data),
      .rd_req          (rd_req),
      .rd_data         (rd_data),
      .duplex_resolved (duplex_resolved)
   );

   function automatic logic [15:0] init_word(int i);
      if (i == 0) return 16'h3100;
      if (i == 2) return 16'h0300;
      if (i == 3) return 16'hE400;
      if (i == 4) return 16'h01E1;
      return 16'h0000;
   endfunction

   function automatic logic exp_dup(logic lk);
      return lk & (mdl[4][8] | mdl[4][6]);
   endfunction

   function automatic logic [15:0] exp_read(logic [7:0] req, logic lk);
      logic [4:0]  n = req[4:0];
      logic [15:0] a = mdl[4];
      case (n)
         5'd1:  return lk ? 16'h782C : 16'h0000;
         5'd5:  return 16'h4000 | (a & 16'h01E0) | 16'h0001;
         5'd18: return lk ? {4'h0, (a[8] | a[6]), (a[7] | a[8]), 10'h000} : 16'h0000;
         default: return mdl[n];
      endcase
   endfunction

   function automatic string tag_of(logic [7:0] req, logic lk);
      case (req[4:0])
         5'd1:  return "R2";
         5'd5:  return "R3";
         5'd18: return lk ? "R5" : "R4";
         default: return "R6";
      endcase
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // drive at negedge, check combinationally, then commit at posedge
   task automatic cycle(logic we, logic [7:0] wreq, logic [15:0] wd,
                        logic [7:0] rreq, logic lk, string tag);
      @(negedge clk);
      wr_en = we; wr_req = wreq; wr_data = wd; rd_req = rreq; link_up = lk;
      #1;
      check(tag, rd_data, exp_read(rreq, lk));
      checks++;
      if (duplex_resolved !== exp_dup(lk)) begin
         errors++;
         $display("FAIL R9: actual %b expected %b", duplex_resolved, exp_dup(lk));
      end
      @(posedge clk);
      if (we) mdl[wreq[4:0]] = wd;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed = 7;
      void'($urandom(seed));
      for (int i = 0; i < 32; i++) mdl[i] = init_word(i);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents of every register
      for (int i = 0; i < 32; i++)
         cycle(1'b0, 8'h00, 16'h0, 8'(i), 1'b1, (i == 1 || i == 5 || i == 18) ? tag_of(8'(i), 1'b1) : "R1");

      // R2: status with link down and up
      cycle(1'b0, 8'h00, 16'h0, 8'd1, 1'b0, "R2");
      cycle(1'b0, 8'h00, 16'h0, 8'd1, 1'b1, "R2");

      // R3, R5, R4: walk the advertisement combinations
      for (int k = 0; k < 16; k++) begin
         cycle(1'b1, 8'd4, 16'({k[3:0], 5'h00}) | 16'h0001, 8'd4, 1'b1, "R6");
         cycle(1'b0, 8'h00, 16'h0, 8'd5, 1'b0, "R3");
         cycle(1'b0, 8'h00, 16'h0, 8'd18, 1'b1, "R5");
         cycle(1'b0, 8'h00, 16'h0, 8'd18, 1'b0, "R4");
      end

      // R7: writes to computed registers do not change their reads
      cycle(1'b1, 8'd1,  16'hFFFF, 8'd0, 1'b1, "R7");
      cycle(1'b1, 8'd5,  16'hFFFF, 8'd1, 1'b1, "R7");
      cycle(1'b1, 8'd18, 16'hFFFF, 8'd5, 1'b1, "R7");
      cycle(1'b0, 8'd0,  16'h0,    8'd18, 1'b1, "R7");
      cycle(1'b0, 8'd0,  16'h0,    8'd1, 1'b0, "R7");

      // R8: upper request bits alias onto the low five
      cycle(1'b1, 8'hE7, 16'hA5A5, 8'h07, 1'b1, "R8");
      cycle(1'b0, 8'h00, 16'h0,    8'h47, 1'b1, "R8");
      cycle(1'b1, 8'h84, 16'h0100, 8'hA4, 1'b1, "R8");
      cycle(1'b0, 8'h00, 16'h0,    8'hF2, 1'b1, "R8");

      // R10: same-cycle read sees old data, next cycle sees new
      cycle(1'b1, 8'd9, 16'h1234, 8'd9, 1'b1, "R10");
      cycle(1'b0, 8'd0, 16'h0,    8'd9, 1'b1, "R10");

      // random traffic, biased toward the computed registers
      for (int t = 0; t < 3000; t++) begin
         logic [7:0] rq = 8'($urandom);
         logic [7:0] wq = 8'($urandom);
         logic       lk = ($urandom % 8) != 0;
         logic       we = $urandom % 2;
         int         pick = $urandom % 6;
         if (pick == 0) rq = {rq[7:5], 5'd18};
         if (pick == 1) rq = {rq[7:5], 5'd5};
         if (pick == 2) wq = {wq[7:5], 5'd4};
         cycle(we, wq, 16'($urandom), rq, lk, tag_of(rq, lk));
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule